// File: doc/BRIEF.md
# Operand Address Generation Unit

This unit resolves the operand or branch target of one instruction in a 16-bit, word-addressed processor. After a start pulse it reads the addressing mode, the instruction's own address, one register-file value and, for jumps, a carry flag and a "conditional" qualifier. When the mode needs a second instruction word, the unit fetches it from the word following the instruction. It may then make a further memory read, and it presents a registered operand or effective address together with the address of the next instruction.

Five modes are handled. Immediate takes the trailing word as the value. Direct treats the trailing word as an address and reads the value from it. Register indirect passes the register value through as the operand address and needs no trailing word. Base adds a signed trailing-word offset to the register. PC relative adds the offset to the address just past the two-word instruction, and can make the jump depend on carry. All additions wrap modulo 2^16. The memory port has a fixed one-cycle read latency, and only one read is in flight at a time.

Top module: `opnd_addr_gen`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `done`, `illegal` and `memRdEn` are 0.
- R2: Mode code 0 (immediate) reads address instrAddr+1 once. Three cycles after start, it gives result = that word and nextPc = instrAddr+2.
- R3: Mode code 1 (direct) reads instrAddr+1 and then the address held in that word. Four cycles after start, it gives result = the second word read and nextPc = instrAddr+2.
- R4: Mode code 2 (register indirect) makes no memory read. One cycle after start, it gives result = regVal and nextPc = instrAddr+1.
- R5: Mode code 3 (base) reads instrAddr+1 once. Three cycles after start, it gives result = (regVal + word) mod 2^16 and nextPc = instrAddr+2.
- R6: Mode code 4 (PC relative) with condJump = 0 reads instrAddr+1. Three cycles after start, it gives result = nextPc = (instrAddr + 2 + word) mod 2^16.
- R7: Mode code 4 with condJump = 1 gives result = the target from R6. nextPc is that target when carry (sampled at start) is 1, and instrAddr+2 when carry is 0.
- R8: Mode codes 5 to 7 make no memory read. One cycle after start, they give done with illegal = 1, result = 0 and nextPc = instrAddr+1. Legal codes give illegal = 0.
- R9: A start pulse that arrives while a request is in progress, including the cycle in which done is high, is ignored. The outputs and the memory traffic are those of the first request only.
- R10: done is high for exactly one cycle per accepted request. result, nextPc and illegal hold their values until the next accepted request completes.
- R11: memRdData is taken in the cycle after memRdEn is asserted. Reads occur only while a request is in progress, never in idle or in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, accepted only when idle |
| mode | input | 3 | Addressing mode code (0 to 4 legal) |
| condJump | input | 1 | PC-relative jump is taken only on carry |
| carry | input | 1 | Carry flag, sampled at start |
| instrAddr | input | 16 | Address of the instruction's first word |
| regVal | input | 16 | Register-file read value, sampled at start |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | 16 | Memory read address |
| memRdData | input | 16 | Read data, valid one cycle after memRdEn |
| result | output | 16 | Operand value or effective address |
| nextPc | output | 16 | Address of the next instruction |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Unused mode code seen on the last request |

## Verification
Some behaviours are checked by the assertions on every cycle. done never lasts two cycles. Register indirect and illegal codes complete in one cycle with no read. The captured context stays unchanged unless a start is accepted. No read is issued in idle or in the done cycle. The bench alone can show the arithmetic: the trailing-word fetch address, the second read in direct mode, the base and PC-relative sums with wraparound, the carry-dependent next PC, and whether a start pulse during a busy request leaves the results unchanged.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;

  typedef enum logic [2:0] {
    MODE_IMM   = 3'd0,
    MODE_DIR   = 3'd1,
    MODE_RIND  = 3'd2,
    MODE_BASE  = 3'd3,
    MODE_PCREL = 3'd4
  } addr_mode_e;

  localparam logic [2:0] LAST_LEGAL_MODE = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_EXT,
    ST_EXT_RDY,
    ST_READ_OPND,
    ST_DONE
  } seq_state_e;

  typedef enum logic [2:0] {
    RES_ZERO,
    RES_REG,
    RES_EXT,
    RES_BASE,
    RES_PCREL,
    RES_MEM
  } res_sel_e;

  typedef enum logic [1:0] {
    NP_ONE,
    NP_TWO,
    NP_JUMP
  } np_sel_e;

  typedef struct packed {
    logic     captureCtx;
    logic     loadRes;
    res_sel_e resSel;
    logic     loadNp;
    np_sel_e  npSel;
    logic     rdEn;
    logic     rdIndirect;
    logic     flagIllegal;
  } dp_strobe_t;

endpackage

// File: rtl/opnd_addr_ctrl.sv
module opnd_addr_ctrl
  import opnd_addr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] mode,
  output dp_strobe_t strobe,
  output logic       done
);

  seq_state_e state, stNext;
  addr_mode_e modeQ;
  logic       legal;

  assign legal = (mode <= LAST_LEGAL_MODE);

  always_comb begin
    strobe = '0;
    stNext = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.captureCtx = 1'b1;
          if (!legal) begin
            strobe.loadRes     = 1'b1;
            strobe.resSel      = RES_ZERO;
            strobe.loadNp      = 1'b1;
            strobe.npSel       = NP_ONE;
            strobe.flagIllegal = 1'b1;
            stNext             = ST_DONE;
          end else if (mode == MODE_RIND) begin
            strobe.loadRes = 1'b1;
            strobe.resSel  = RES_REG;
            strobe.loadNp  = 1'b1;
            strobe.npSel   = NP_ONE;
            stNext         = ST_DONE;
          end else begin
            stNext = ST_FETCH_EXT;
          end
        end
      end
      ST_FETCH_EXT: begin
        strobe.rdEn = 1'b1;
        stNext      = ST_EXT_RDY;
      end
      ST_EXT_RDY: begin
        stNext = ST_DONE;
        case (modeQ)
          MODE_DIR: begin
            strobe.rdEn       = 1'b1;
            strobe.rdIndirect = 1'b1;
            stNext            = ST_READ_OPND;
          end
          MODE_IMM: begin
            strobe.loadRes = 1'b1;
            strobe.resSel  = RES_EXT;
            strobe.loadNp  = 1'b1;
            strobe.npSel   = NP_TWO;
          end
          MODE_BASE: begin
            strobe.loadRes = 1'b1;
            strobe.resSel  = RES_BASE;
            strobe.loadNp  = 1'b1;
            strobe.npSel   = NP_TWO;
          end
          MODE_PCREL: begin
            strobe.loadRes = 1'b1;
            strobe.resSel  = RES_PCREL;
            strobe.loadNp  = 1'b1;
            strobe.npSel   = NP_JUMP;
          end
          default: ;
        endcase
      end
      ST_READ_OPND: begin
        strobe.loadRes = 1'b1;
        strobe.resSel  = RES_MEM;
        strobe.loadNp  = 1'b1;
        strobe.npSel   = NP_TWO;
        stNext         = ST_DONE;
      end
      ST_DONE: stNext = ST_IDLE;
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      modeQ <= MODE_IMM;
    end else begin
      state <= stNext;
      if (strobe.captureCtx && legal) modeQ <= addr_mode_e'(mode);
    end
  end

  assign done = (state == ST_DONE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_ILLEGAL_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && !legal) |=> (done && !strobe.rdEn)); // R8

  AST_RIND_SHORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && mode == MODE_RIND) |=> (done && !strobe.rdEn)); // R4

  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_DONE) |-> !strobe.rdEn); // R11

endmodule

// File: rtl/opnd_addr_dp.sv
module opnd_addr_dp
  import opnd_addr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  dp_strobe_t   strobe,
  input  logic [W-1:0] instrAddr,
  input  logic [W-1:0] regVal,
  input  logic         condJump,
  input  logic         carry,
  input  logic [W-1:0] memRdData,
  output logic         memRdEn,
  output logic [W-1:0] memAddr,
  output logic [W-1:0] result,
  output logic [W-1:0] nextPc,
  output logic         illegal
);

  logic [W-1:0] pcQ, regQ, resultQ, nextPcQ;
  logic         condQ, carryQ, illegalQ;
  logic [W-1:0] pcSrc, regSrc, pcPlus1, pcPlus2, target, baseEa;
  logic [W-1:0] resNext, npNext;

  assign pcSrc   = strobe.captureCtx ? instrAddr : pcQ;
  assign regSrc  = strobe.captureCtx ? regVal : regQ;
  assign pcPlus1 = pcSrc + W'(1);
  assign pcPlus2 = pcSrc + W'(2);
  assign target  = pcPlus2 + memRdData;
  assign baseEa  = regSrc + memRdData;

  always_comb begin
    case (strobe.resSel)
      RES_REG:   resNext = regSrc;
      RES_EXT:   resNext = memRdData;
      RES_BASE:  resNext = baseEa;
      RES_PCREL: resNext = target;
      RES_MEM:   resNext = memRdData;
      default:   resNext = '0;
    endcase
  end

  always_comb begin
    case (strobe.npSel)
      NP_ONE:  npNext = pcPlus1;
      NP_TWO:  npNext = pcPlus2;
      NP_JUMP: npNext = (condQ && !carryQ) ? pcPlus2 : target;
      default: npNext = pcPlus1;
    endcase
  end

  assign memRdEn = strobe.rdEn;
  assign memAddr = strobe.rdIndirect ? memRdData : pcPlus1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ      <= '0;
      regQ     <= '0;
      condQ    <= 1'b0;
      carryQ   <= 1'b0;
      resultQ  <= '0;
      nextPcQ  <= '0;
      illegalQ <= 1'b0;
    end else begin
      if (strobe.captureCtx) begin
        pcQ    <= instrAddr;
        regQ   <= regVal;
        condQ  <= condJump;
        carryQ <= carry;
      end
      if (strobe.loadRes) begin
        resultQ  <= resNext;
        illegalQ <= strobe.flagIllegal;
      end
      if (strobe.loadNp) nextPcQ <= npNext;
    end
  end

  assign result  = resultQ;
  assign nextPc  = nextPcQ;
  assign illegal = illegalQ;

  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureCtx |=> ($stable(pcQ) && $stable(regQ) && $stable(carryQ))); // R9

  AST_NO_LOAD_WHILE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && !strobe.rdIndirect) |-> !strobe.loadRes); // R11

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import opnd_addr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic         condJump,
  input  logic         carry,
  input  logic [W-1:0] instrAddr,
  input  logic [W-1:0] regVal,
  output logic         memRdEn,
  output logic [W-1:0] memAddr,
  input  logic [W-1:0] memRdData,
  output logic [W-1:0] result,
  output logic [W-1:0] nextPc,
  output logic         done,
  output logic         illegal
);

  dp_strobe_t strobe;

  opnd_addr_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .mode   (mode),
    .strobe (strobe),
    .done   (done)
  );

  opnd_addr_dp #(.W(W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instrAddr (instrAddr),
    .regVal    (regVal),
    .condJump  (condJump),
    .carry     (carry),
    .memRdData (memRdData),
    .memRdEn   (memRdEn),
    .memAddr   (memAddr),
    .result    (result),
    .nextPc    (nextPc),
    .illegal   (illegal)
  );

  AST_DONE_LEGAL_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegal) |-> !memRdEn); // R8

endmodule

// File: tb/test_opnd_addr_gen.sv
`timescale 1ns/1ps
module test_opnd_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic        condJump = 1'b0;
  logic        carry = 1'b0;
  logic [15:0] instrAddr = '0;
  logic [15:0] regVal = '0;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [15:0] memRdData = '0;
  logic [15:0] result, nextPc;
  logic        done, illegal;

  int nChecks = 0;
  int nFail = 0;
  int rdCount = 0;
  logic [15:0] rdAddr0 = '0, rdAddr1 = '0;
  logic        ovEn = 1'b0;
  logic [15:0] ovAddr = '0, ovData = '0;

  always #2 clk = ~clk;

  opnd_addr_gen i_opnd_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .condJump(condJump),
    .carry(carry), .instrAddr(instrAddr), .regVal(regVal), .memRdEn(memRdEn),
    .memAddr(memAddr), .memRdData(memRdData), .result(result), .nextPc(nextPc),
    .done(done), .illegal(illegal)
  );

  function automatic logic [15:0] memVal(input logic [15:0] a);
    logic [31:0] p;
    if (ovEn && a == ovAddr) return ovData;
    p = {16'h0, a} * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) begin
      memRdData <= memVal(memAddr);
      if (rdCount == 0) rdAddr0 = memAddr;
      else rdAddr1 = memAddr;
      rdCount++;
    end
  end

  function automatic logic [15:0] expResult(input logic [2:0] m, input logic [15:0] pc, rg);
    logic [15:0] ext;
    ext = memVal(pc + 16'd1);
    case (m)
      3'd0: return ext;
      3'd1: return memVal(ext);
      3'd2: return rg;
      3'd3: return rg + ext;
      3'd4: return pc + 16'd2 + ext;
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic [15:0] expNextPc(input logic [2:0] m, input logic [15:0] pc,
                                            input logic cj, cy);
    logic [15:0] tgt;
    tgt = pc + 16'd2 + memVal(pc + 16'd1);
    case (m)
      3'd0, 3'd1, 3'd3: return pc + 16'd2;
      3'd4: return (cj && !cy) ? pc + 16'd2 : tgt;
      default: return pc + 16'd1;
    endcase
  endfunction

  function automatic int expLatency(input logic [2:0] m);
    case (m)
      3'd0, 3'd3, 3'd4: return 3;
      3'd1: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic int expReads(input logic [2:0] m);
    case (m)
      3'd0, 3'd3, 3'd4: return 1;
      3'd1: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic string modeReq(input logic [2:0] m, input logic cj);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return cj ? "R7" : "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] m, input logic [15:0] pc, rg,
                       input logic cj, cy, input logic poke);
    logic [15:0] eRes, eNp;
    int eLat, eRd, cyc, rdSnap;
    string rq;
    eRes = expResult(m, pc, rg);
    eNp  = expNextPc(m, pc, cj, cy);
    eLat = expLatency(m);
    eRd  = expReads(m);
    rq   = modeReq(m, cj);
    @(negedge clk);
    rdCount = 0;
    start = 1'b1; mode = m; instrAddr = pc; regVal = rg; condJump = cj; carry = cy;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    if (poke) begin
      start = 1'b1; mode = 3'd2; instrAddr = ~pc; regVal = ~rg; carry = ~cy;
    end
    while (!done && cyc < 20) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    check(cyc == eLat, rq, "latency", cyc, eLat);
    check(result == eRes, rq, "result", result, eRes);
    check(nextPc == eNp, rq, "nextPc", nextPc, eNp);
    check(illegal == (m > 3'd4), "R8", "illegal", illegal, (m > 3'd4));
    check(rdCount == eRd, (eRd == 0) ? "R8" : "R11", "reads", rdCount, eRd);
    if (eRd >= 1) check(rdAddr0 == pc + 16'd1, rq, "ext addr", rdAddr0, pc + 16'd1);
    if (eRd == 2) check(rdAddr1 == memVal(pc + 16'd1), "R3", "opnd addr", rdAddr1,
                        memVal(pc + 16'd1));
    @(negedge clk);
    start = 1'b0;
    check(!done, "R10", "done pulse", done, 0);
    rdSnap = rdCount;
    repeat (3) @(negedge clk);
    check(!done && rdCount == rdSnap, "R9", "no second request", {done, 8'(rdCount)},
          {1'b0, 8'(rdSnap)});
    check(result == eRes && nextPc == eNp, "R10", "hold", result, eRes);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!done && !illegal && !memRdEn, "R1", "in reset", {done, illegal, memRdEn}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !illegal && !memRdEn, "R1", "after reset", {done, illegal, memRdEn}, 0);

    // Directed corner cases
    runOp(3'd0, 16'h017A, 16'h0000, 1'b0, 1'b0, 1'b0);          // R2
    runOp(3'd1, 16'h0200, 16'h0000, 1'b0, 1'b0, 1'b0);          // R3
    runOp(3'd2, 16'h0300, 16'h875F, 1'b0, 1'b0, 1'b0);          // R4
    ovEn = 1'b1; ovAddr = 16'h017B; ovData = 16'hA39D;
    runOp(3'd3, 16'h017A, 16'h1700, 1'b0, 1'b0, 1'b0);          // R5: 0xBA9D
    check(result == 16'hBA9D, "R5", "base example", result, 16'hBA9D);
    ovData = 16'h439D;
    runOp(3'd4, 16'h017A, 16'h0000, 1'b0, 1'b0, 1'b0);          // R6: 0x4519
    check(nextPc == 16'h4519, "R6", "pcrel example", nextPc, 16'h4519);
    runOp(3'd4, 16'h017A, 16'h0000, 1'b1, 1'b1, 1'b0);          // R7 taken
    runOp(3'd4, 16'h017A, 16'h0000, 1'b1, 1'b0, 1'b0);          // R7 not taken
    check(nextPc == 16'h017C, "R7", "not taken", nextPc, 16'h017C);
    ovEn = 1'b0;
    runOp(3'd4, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0);          // R6 wrap
    runOp(3'd3, 16'hFFFE, 16'hFFF0, 1'b0, 1'b0, 1'b0);          // R5 wrap
    runOp(3'd5, 16'h1234, 16'h5555, 1'b0, 1'b0, 1'b0);          // R8
    runOp(3'd7, 16'hFFFF, 16'h5555, 1'b0, 1'b0, 1'b0);          // R8
    runOp(3'd1, 16'h0400, 16'h0000, 1'b0, 1'b0, 1'b1);          // R9 poke
    runOp(3'd2, 16'h0500, 16'hBEEF, 1'b0, 1'b0, 1'b1);          // R9 poke in done

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      runOp(3'($urandom_range(0, 7)), 16'($urandom), 16'($urandom),
            1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule